// File: doc/BRIEF.md
# Parallel flash command sequencer

This block models the command side of a byte-wide parallel NOR flash over a small internal byte array. Each bus write is presented as an address and a data byte. The block watches these writes for a two-write unlock pattern, and a command byte must follow that pattern. The unlock and command cycles are matched on the low 11 address bits only. The accepted command sets the operating mode: plain array reads (READ), identification (IDENT), byte programming (PROG), or a pending erase that waits for its erase type (ERASE_WAIT). The erase operation itself is not carried out.

A read returns one of three things, and the mode at the time of the read picks which: a stored byte, an identification value, or the protection flag of one sector group. Read data appears one cycle after the read strobe. A protection register holds one flag for each sector group. A separate load strobe fills this register, and an identification read at the protection offset reports the flag in bit 0. In programming mode a write can only clear bits, because the byte stored is the AND of the old byte and the new data.

The unlock tracker has three states: UNL_IDLE, UNL_GOT_FIRST and UNL_GOT_SECOND. Its transitions are:
- UNL_IDLE to UNL_GOT_FIRST on the first key.
- UNL_GOT_FIRST to UNL_GOT_SECOND on the second key.
- UNL_GOT_FIRST to UNL_IDLE on any other write.
- UNL_GOT_SECOND to UNL_IDLE on any write.

The mode machine has four states: READ, IDENT, PROG and ERASE_WAIT. It changes state only on a command write that arrives in UNL_GOT_SECOND.

Top module: `pflash_cmd_seq`

## Requirements
- R1: A synchronous reset puts the block in READ mode with the unlock tracker in UNL_IDLE. It fills every array byte with 0xFF, clears all protection flags, and makes rdata read 0xFF.
- R2: In UNL_IDLE, only a write of 0xAA where addr[10:0] == 0x555 moves the tracker to UNL_GOT_FIRST. Any other write leaves it in UNL_IDLE and does not change the mode. Address bits above bit 10 are ignored.
- R3: In UNL_GOT_FIRST, a write of 0x55 where addr[10:0] == 0x2AA moves the tracker to UNL_GOT_SECOND. Any other write returns it to UNL_IDLE.
- R4: In UNL_GOT_SECOND, a write where addr[10:0] == 0x555 selects the mode from its data: 0xF0 gives READ, 0x90 gives IDENT, 0xA0 gives PROG and 0x80 gives ERASE_WAIT. Any other data, or any other address, leaves the mode unchanged.
- R5: Any write in UNL_GOT_SECOND returns the tracker to UNL_IDLE, whatever the command was.
- R6: While the block is in PROG mode, every write, unlock writes included, replaces byte addr[ARR_AW-1:0] with (old AND wdata). A write in any other mode leaves the array unchanged.
- R7: In IDENT mode, a read decodes addr[1:0] only and returns:
  - 0 gives 0x01.
  - 1 gives 0xD5.
  - 2 gives the protection flag of group addr[19:17] in bit 0, with bits 7:1 zero.
  - 3 gives 0xFF.
- R8: A read in PROG or ERASE_WAIT mode returns 0xFF.
- R9: In READ mode, a read strobe at one clock edge makes rdata show byte addr[ARR_AW-1:0] after that edge. rdata holds its value until the next read strobe.
- R10: A protection load strobe copies prot_bits into the protection register, and bit g is the flag for group g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| prot_load | input | 1 | Load strobe for the protection register |
| prot_bits | input | 2**GRP_W | New protection flags, one per group |
| rdata | output | 8 | Read data, one cycle after rd_en |

## Verification
The read-data assertions assume that rd_en and wr_en are never high in the same cycle, so the mode seen by a read is the one in force before any command lands. The bench runs every access as a separate strobe cycle and never overlaps a read with a write. The assertions also assume that rst is high from time zero, which the bench holds for several cycles at start-up.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {MODE_READ, MODE_IDENT, MODE_PROG, MODE_ERASE_WAIT} mode_e;
    typedef enum logic [1:0] {UNL_IDLE, UNL_GOT_FIRST, UNL_GOT_SECOND} unl_e;
    typedef enum logic [1:0] {SRC_NONE, SRC_ARRAY, SRC_IDENT} src_e;

    localparam int           MATCH_W    = 11;
    localparam logic [10:0]  KEY_ADDR_A = 11'h555;
    localparam logic [10:0]  KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]   KEY_DATA_A = 8'hAA;
    localparam logic [7:0]   KEY_DATA_B = 8'h55;

    localparam logic [7:0]   OP_EXIT    = 8'hF0;
    localparam logic [7:0]   OP_IDENT   = 8'h90;
    localparam logic [7:0]   OP_PROG    = 8'hA0;
    localparam logic [7:0]   OP_ERASE   = 8'h80;

    localparam logic [7:0]   MFR_CODE   = 8'h01;
    localparam logic [7:0]   DEV_CODE   = 8'hD5;
    localparam logic [7:0]   BLANK      = 8'hFF;
endpackage

// File: rtl/pfc_unlock.sv
module pfc_unlock
    import pfc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [MATCH_W-1:0]  addr_lo,
    input  logic [7:0]          wdata,
    output unl_e                state,
    output logic                cmd_stb,
    output logic [7:0]          cmd_code
);
    unl_e state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= UNL_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        cmd_stb   = 1'b0;
        cmd_code  = wdata;
        if (wr_en) begin
            unique case (state)
                UNL_IDLE:
                    if (addr_lo == KEY_ADDR_A && wdata == KEY_DATA_A) state_nxt = UNL_GOT_FIRST;
                UNL_GOT_FIRST:
                    if (addr_lo == KEY_ADDR_B && wdata == KEY_DATA_B) state_nxt = UNL_GOT_SECOND;
                    else                                              state_nxt = UNL_IDLE;
                UNL_GOT_SECOND: begin
                    state_nxt = UNL_IDLE;
                    cmd_stb   = (addr_lo == KEY_ADDR_A);
                end
                default: state_nxt = UNL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
    parameter int ARR_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ARR_AW-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        q
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            q <= 8'hFF;
        end else begin
            if (we) mem[idx] <= mem[idx] & wdata;
            if (re) q <= mem[idx];
        end
    end
endmodule

// File: rtl/pfc_ident.sv
module pfc_ident
    import pfc_pkg::*;
#(
    parameter int GRP_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 re,
    input  logic [1:0]           offset,
    input  logic [GRP_W-1:0]     grp,
    input  logic [(1<<GRP_W)-1:0] prot,
    output logic [7:0]           q
);
    logic [7:0] code;

    always_comb begin
        unique case (offset)
            2'd0:    code = MFR_CODE;
            2'd1:    code = DEV_CODE;
            2'd2:    code = {7'd0, prot[grp]};
            default: code = BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= BLANK;
        else if (re) q <= code;
    end
endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
    import pfc_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int ARR_AW  = 8,
    parameter int GRP_LSB = 17,
    parameter int GRP_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [7:0]              wdata,
    input  logic                    prot_load,
    input  logic [(1<<GRP_W)-1:0]   prot_bits,
    output logic [7:0]              rdata
);
    localparam int NGRP = 1 << GRP_W;

    unl_e            unl_state;
    logic            cmd_stb;
    logic [7:0]      cmd_code;
    mode_e           mode_q, mode_nxt;
    src_e            src_q, src_nxt;
    logic            arr_we;
    logic [7:0]      arr_q, id_q;
    logic [NGRP-1:0] prot_q;

    pfc_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr_lo  (addr[MATCH_W-1:0]),
        .wdata    (wdata),
        .state    (unl_state),
        .cmd_stb  (cmd_stb),
        .cmd_code (cmd_code)
    );

    // mode state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_READ;
        else     mode_q <= mode_nxt;
    end

    always_comb begin
        mode_nxt = mode_q;
        if (cmd_stb) begin
            case (cmd_code)
                OP_EXIT:  mode_nxt = MODE_READ;
                OP_IDENT: mode_nxt = MODE_IDENT;
                OP_PROG:  mode_nxt = MODE_PROG;
                OP_ERASE: mode_nxt = MODE_ERASE_WAIT;
                default:  mode_nxt = mode_q;
            endcase
        end
    end

    // per-mode outputs
    always_comb begin
        arr_we  = 1'b0;
        src_nxt = SRC_NONE;
        unique case (mode_q)
            MODE_READ:       src_nxt = SRC_ARRAY;
            MODE_IDENT:      src_nxt = SRC_IDENT;
            MODE_PROG:       arr_we  = wr_en;
            MODE_ERASE_WAIT: src_nxt = SRC_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= SRC_NONE;
            prot_q <= '0;
        end else begin
            if (rd_en)     src_q  <= src_nxt;
            if (prot_load) prot_q <= prot_bits;
        end
    end

    pfc_array #(.ARR_AW(ARR_AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .re    (rd_en),
        .idx   (addr[ARR_AW-1:0]),
        .wdata (wdata),
        .q     (arr_q)
    );

    pfc_ident #(.GRP_W(GRP_W)) u_ident (
        .clk    (clk),
        .rst    (rst),
        .re     (rd_en),
        .offset (addr[1:0]),
        .grp    (addr[GRP_LSB +: GRP_W]),
        .prot   (prot_q),
        .q      (id_q)
    );

    always_comb begin
        unique case (src_q)
            SRC_ARRAY: rdata = arr_q;
            SRC_IDENT: rdata = id_q;
            default:   rdata = BLANK;
        endcase
    end
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  unl_e              unl_state,
    input  mode_e             mode,
    input  logic [7:0]        rdata
);
    logic key_a, key_b, at_a;
    assign at_a  = (addr[10:0] == 11'h555);
    assign key_a = at_a && (wdata == 8'hAA);
    assign key_b = (addr[10:0] == 11'h2AA) && (wdata == 8'h55);

    AST_FIRST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_IDLE && wr_en && key_a) |=> unl_state == UNL_GOT_FIRST); // R2
    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_IDLE && wr_en && !key_a) |=> unl_state == UNL_IDLE); // R2
    AST_IDLE_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_IDLE && wr_en) |=> $stable(mode)); // R2
    AST_SECOND_MISS: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_GOT_FIRST && wr_en && !key_b) |=> unl_state == UNL_IDLE); // R3
    AST_CMD_IDENT: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_GOT_SECOND && wr_en && at_a && wdata == 8'h90) |=> mode == MODE_IDENT); // R4
    AST_CMD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_GOT_SECOND && wr_en && at_a && wdata == 8'hF0) |=> mode == MODE_READ); // R4
    AST_THIRD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (unl_state == UNL_GOT_SECOND && wr_en) |=> unl_state == UNL_IDLE); // R5
    AST_ID_DEV: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && mode == MODE_IDENT && addr[1:0] == 2'd1) |=> rdata == 8'hD5); // R7
    AST_UNDEF_BLANK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && (mode == MODE_PROG || mode == MODE_ERASE_WAIT)) |=> rdata == 8'hFF); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R9
endmodule

bind pflash_cmd_seq pfc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .unl_state (unl_state),
    .mode      (mode_q),
    .rdata     (rdata)
);

// File: tb/tb_pflash_cmd_seq.sv
module tb_pflash_cmd_seq;
    localparam int ADDR_W = 20;
    localparam int NVEC   = 52;
    // fields: [41:38] requirement, [37:36] op (0 write, 1 read+check, 2 protection load),
    //         [35:16] address, [15:8] data, [7:0] expected read value
    localparam logic [41:0] VEC [NVEC] = '{
        {4'd1, 2'd1, 20'h00010, 8'h00, 8'hFF},  // R1 blank array
        {4'd10,2'd2, 20'h00000, 8'hA5, 8'h00},  // R10 load flags
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00555, 8'h90, 8'h00},  // R4 enter IDENT
        {4'd7, 2'd1, 20'h00000, 8'h00, 8'h01},  // R7 manufacturer
        {4'd7, 2'd1, 20'h7FFF1, 8'h00, 8'hD5},  // R7 device, upper bits ignored
        {4'd7, 2'd1, 20'h00002, 8'h00, 8'h01},  // R7 group 0 flag
        {4'd7, 2'd1, 20'h20002, 8'h00, 8'h00},  // R7 group 1 flag
        {4'd7, 2'd1, 20'hE0002, 8'h00, 8'h01},  // R7 group 7 flag
        {4'd7, 2'd1, 20'h00003, 8'h00, 8'hFF},  // R7 undefined offset
        {4'd2, 2'd0, 20'h1F555, 8'hAA, 8'h00},  // R2 upper bits masked
        {4'd3, 2'd0, 20'h3F2AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00555, 8'hA0, 8'h00},  // enter PROG
        {4'd8, 2'd1, 20'h00010, 8'h00, 8'hFF},  // R8 read in PROG
        {4'd6, 2'd0, 20'h00010, 8'h3C, 8'h00},
        {4'd6, 2'd0, 20'h00010, 8'hF5, 8'h00},  // R6 AND -> 34
        {4'd6, 2'd0, 20'h00020, 8'h0F, 8'h00},
        {4'd6, 2'd0, 20'h00555, 8'hAA, 8'h00},  // also ANDs byte 0x55
        {4'd6, 2'd0, 20'h002AA, 8'h55, 8'h00},  // also ANDs byte 0xAA
        {4'd4, 2'd0, 20'h00555, 8'hF0, 8'h00},  // byte 0x55 -> A0, back to READ
        {4'd6, 2'd1, 20'h00010, 8'h00, 8'h34},  // R6
        {4'd6, 2'd1, 20'h00020, 8'h00, 8'h0F},  // R6
        {4'd6, 2'd1, 20'h00055, 8'h00, 8'hA0},  // R6 unlock writes programmed too
        {4'd6, 2'd0, 20'h00030, 8'h00, 8'h00},  // write in READ ignored
        {4'd6, 2'd1, 20'h00030, 8'h00, 8'hFF},  // R6
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00555, 8'h80, 8'h00},  // enter ERASE_WAIT
        {4'd8, 2'd1, 20'h00010, 8'h00, 8'hFF},  // R8 read in ERASE_WAIT
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00555, 8'hF0, 8'h00},
        {4'd4, 2'd1, 20'h00010, 8'h00, 8'h34},  // R4 exit to READ
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h54, 8'h00},  // bad second key
        {4'd3, 2'd0, 20'h00555, 8'h90, 8'h00},  // idle, not a key
        {4'd3, 2'd1, 20'h00010, 8'h00, 8'h34},  // R3 still READ
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00554, 8'h90, 8'h00},  // wrong third address
        {4'd4, 2'd1, 20'h00010, 8'h00, 8'h34},  // R4 mode unchanged
        {4'd5, 2'd0, 20'h00555, 8'h90, 8'h00},  // tracker must be idle
        {4'd5, 2'd1, 20'h00010, 8'h00, 8'h34},  // R5
        {4'd2, 2'd0, 20'h00555, 8'hAA, 8'h00},
        {4'd3, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd4, 2'd0, 20'h00555, 8'h12, 8'h00},  // unknown command
        {4'd4, 2'd1, 20'h00010, 8'h00, 8'h34},  // R4
        {4'd2, 2'd0, 20'h00556, 8'hAA, 8'h00},  // wrong first address
        {4'd2, 2'd0, 20'h002AA, 8'h55, 8'h00},
        {4'd2, 2'd0, 20'h00555, 8'h90, 8'h00},
        {4'd2, 2'd1, 20'h00010, 8'h00, 8'h34}   // R2 no unlock happened
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0, rd_en = 1'b0, prot_load = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        prot_bits = '0;
    logic [7:0]        rdata;
    int                n_chk = 0, n_bad = 0;
    bit                done = 1'b0;

    always #10 clk = ~clk;

    pflash_cmd_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .prot_load(prot_load), .prot_bits(prot_bits), .rdata(rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%02h expected %02h", req, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [19:0] a, input logic [7:0] d,
                        input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; wdata = d; prot_bits = d;
        wr_en = (op == 2'd0); rd_en = (op == 2'd1); prot_load = (op == 2'd2);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; prot_load = 1'b0;
        if (op == 2'd1) check(req, rdata, exp);
    endtask

    task automatic unlock(input logic [7:0] cmd);
        step(2'd0, 20'h00555, 8'hAA, 8'h00, "unlock");
        step(2'd0, 20'h002AA, 8'h55, 8'h00, "unlock");
        step(2'd0, 20'h00555, cmd, 8'h00, "unlock");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++)
            step(VEC[i][37:36], VEC[i][35:16], VEC[i][15:8], VEC[i][7:0],
                 $sformatf("R%0d vec%0d", VEC[i][41:38], i));
        // R9: output holds with no read strobe
        step(2'd1, 20'h00020, 8'h00, 8'h0F, "R9 read");
        repeat (3) @(negedge clk);
        check("R9 hold", rdata, 8'h0F);
        // R1: reset returns everything to defaults
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 rdata after reset", rdata, 8'hFF);
        step(2'd1, 20'h00010, 8'h00, 8'hFF, "R1 array blank");
        step(2'd1, 20'h00002, 8'h00, 8'hFF, "R1 READ mode");
        unlock(8'h90);
        step(2'd1, 20'h00002, 8'h00, 8'h00, "R1 flags cleared");
        // R10: load in IDENT mode, then query
        step(2'd2, 20'h00000, 8'h01, 8'h00, "R10 load");
        step(2'd1, 20'h00002, 8'h00, 8'h01, "R10 group 0");
        step(2'd1, 20'h20002, 8'h00, 8'h00, "R10 group 1");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule